// File: doc/BRIEF.md
# Keyed System Status Register Bank

This block is a small memory-mapped bank of board status and control registers on a plain 32-bit register bus. The bus carries a byte offset, a write strobe and write data, and returns read data combinationally from the offset. The bank holds several kinds of register. An identity word is fixed when the block is built. A software-owned LED word comes next. Two set/clear flag words follow, one cleared by reset and one that survives it. A lock word must hold a 16-bit key before the reset-control word accepts writes. A display-control word has partly read-only bits, and a card-status word mirrors two board pins.

Bits [27:16] of the identity word carry a board-variant code. This code decides, at elaboration time, the following:
- whether reset control exists;
- which data bit in reset control raises the reset request;
- which display-control bits are writable;
- whether a 2-bit display mux output is driven;
- where the write-protect pin appears in the card-status word.

An accepted reset-control write with the trigger bit set produces a single-cycle reset request pulse.

Top module: `sysstat_bank`

## Requirements
- R1: A read at offset 0x00 returns the identity word given by parameter `ID_WORD`, and writes there are ignored.
- R2: Offset 0x08 is a 32-bit read/write LED word that reset clears to zero.
- R3: A write to offset 0x20 of exactly 0x0000A05F stores key 0xA05F in the 16-bit lock word. Any other write stores write-data bits [14:0] with bit 15 forced to 0. Reads return the lock word in bits [15:0] with zeros above. Reset clears it.
- R4: A write to offset 0x30 ORs the data into the volatile flag word. A write to 0x34 clears every flag bit that is 1 in the data. Offset 0x30 reads the flag word and 0x34 reads zero. Reset clears the flag word.
- R5: Offsets 0x38 and 0x3C set and clear the persistent flag word in the same way, and 0x38 reads it. Reset leaves this word unchanged.
- R6: For variant codes 0x100, 0x178 and 0x182, a write to 0x40 stores the data only while the lock word holds 0xA05F. A read of 0x40 returns the stored word, and reset clears it. For every other code, 0x40 reads zero and ignores writes.
- R7: The clock edge that accepts a reset-control write drives `resetReq` high for exactly one cycle, if the trigger bit of the data is 1. The trigger bit is bit 8 for variant 0x100 and bit 2 for 0x178 and 0x182.
- R8: Reset sets the display-control word at 0x50 to 0x00001F00. For variant 0x190 the reset value is 0, and the word reads zero and ignores writes.
- R9: For variants 0x100 and 0x140, display-control bits [13:8] keep their value on a write and all other bits take the write data. For 0x178 and 0x182, only bit 7 takes the write data.
- R10: For variant 0x100, a display-control write loads write-data bits [1:0] into `muxCtrl` at the accepting edge. For all other variants `muxCtrl` stays 0. Reset clears it.
- R11: The card-status word at 0x48 holds `cardDetect` in bit 0 and `writeProt` in bit 2 (variants 0x100 and 0x140) or bit 1 (other variants). Both pins are registered once. Every other bit reads 0, and writes are ignored.
- R12: Reads of any offset not listed above return zero, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte offset of the access; bits [1:0] are ignored |
| busWrite | input | 1 | Write strobe, sampled at the rising edge |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for the current offset, combinational |
| cardDetect | input | 1 | Card present pin |
| writeProt | input | 1 | Card write-protect pin |
| resetReq | output | 1 | Single-cycle reset request |
| muxCtrl | output | MUX_W | Display format mux select |

## Verification
Five instances, one per variant code, receive the same writes of several data patterns to every word offset. All 64 offsets of each instance are then read back against a model of the rules above. The bench goes after these corner cases:
- A key written with extra high bits must not unlock the bank. A design comparing only the low half would unlock and accept a reset-control write.
- The trigger bit differs between variants. A swapped bit would pulse `resetReq` on the wrong variant or not at all.
- The read-only display bits differ between variants. A wrong mask would show up as a changed bit [13:8] or bit 7 after an all-ones write.
- The persistent flag word must stay intact over a reset. A design that clears it there would miscompare on the read-back that follows.

// File: rtl/sysstat_pkg.sv
package sysstat_pkg;

  typedef enum logic [2:0] {
    BRD_A, BRD_B, BRD_C, BRD_D, BRD_E, BRD_X
  } board_e;

  localparam int OFF_ID   = 'h00;
  localparam int OFF_LED  = 'h08;
  localparam int OFF_LOCK = 'h20;
  localparam int OFF_FSET = 'h30;
  localparam int OFF_FCLR = 'h34;
  localparam int OFF_NSET = 'h38;
  localparam int OFF_NCLR = 'h3C;
  localparam int OFF_RST  = 'h40;
  localparam int OFF_MCI  = 'h48;
  localparam int OFF_CLCD = 'h50;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_ID, SEL_LED, SEL_LOCK, SEL_FLAGS,
    SEL_NV, SEL_RST, SEL_MCI, SEL_CLCD
  } rdsel_e;

  typedef struct packed {
    logic ledWr;
    logic lockWr;
    logic flagSet;
    logic flagClr;
    logic nvSet;
    logic nvClr;
    logic rstWr;
    logic clcdWr;
  } strobe_t;

  function automatic board_e boardOf(input logic [31:0] id);
    case (id[27:16])
      12'h100: return BRD_A;
      12'h140: return BRD_B;
      12'h178: return BRD_C;
      12'h182: return BRD_D;
      12'h190: return BRD_E;
      default: return BRD_X;
    endcase
  endfunction

  function automatic bit hasResetCtl(input board_e b);
    return (b == BRD_A) || (b == BRD_C) || (b == BRD_D);
  endfunction

  function automatic int resetTrigBit(input board_e b);
    return (b == BRD_A) ? 8 : 2;
  endfunction

  // Bits set in this mask keep their value on a display-control write.
  function automatic logic [31:0] clcdKeepMask(input board_e b);
    case (b)
      BRD_A, BRD_B: return 32'h0000_3F00;
      BRD_C, BRD_D: return ~32'h0000_0080;
      default:      return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] clcdInit(input board_e b);
    return (b == BRD_E) ? 32'h0 : 32'h0000_1F00;
  endfunction

  function automatic int wpBit(input board_e b);
    return ((b == BRD_A) || (b == BRD_B)) ? 2 : 1;
  endfunction

  function automatic bit hasMux(input board_e b);
    return b == BRD_A;
  endfunction

endpackage

// File: rtl/sysstat_ctrl.sv
module sysstat_ctrl
  import sysstat_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter logic [31:0] ID_WORD = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              lockOpen,
  output strobe_t           strb,
  output rdsel_e            rdSel
);

  localparam int     WORD_W = ADDR_W - 2;
  localparam board_e BOARD  = boardOf(ID_WORD);
  localparam bit     RST_EN = hasResetCtl(BOARD);

  logic [WORD_W-1:0] wordIdx;
  logic              unusedLowBits;

  assign wordIdx       = busAddr[ADDR_W-1:2];
  assign unusedLowBits = ^busAddr[1:0];

  always_comb begin
    strb  = '0;
    rdSel = SEL_ZERO;
    case (wordIdx)
      WORD_W'(OFF_ID >> 2):   rdSel = SEL_ID;
      WORD_W'(OFF_LED >> 2): begin
        rdSel      = SEL_LED;
        strb.ledWr = busWrite;
      end
      WORD_W'(OFF_LOCK >> 2): begin
        rdSel       = SEL_LOCK;
        strb.lockWr = busWrite;
      end
      WORD_W'(OFF_FSET >> 2): begin
        rdSel        = SEL_FLAGS;
        strb.flagSet = busWrite;
      end
      WORD_W'(OFF_FCLR >> 2): strb.flagClr = busWrite;
      WORD_W'(OFF_NSET >> 2): begin
        rdSel      = SEL_NV;
        strb.nvSet = busWrite;
      end
      WORD_W'(OFF_NCLR >> 2): strb.nvClr = busWrite;
      WORD_W'(OFF_RST >> 2): begin
        rdSel      = RST_EN ? SEL_RST : SEL_ZERO;
        strb.rstWr = busWrite && lockOpen && RST_EN;
      end
      WORD_W'(OFF_MCI >> 2):  rdSel = SEL_MCI;
      WORD_W'(OFF_CLCD >> 2): begin
        rdSel       = SEL_CLCD;
        strb.clcdWr = busWrite && (BOARD != BRD_E) && (BOARD != BRD_X);
      end
      default: ;
    endcase
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R12

endmodule

// File: rtl/sysstat_dp.sv
module sysstat_dp
  import sysstat_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          LOCK_W   = 16,
  parameter int          MUX_W    = 2,
  parameter logic [15:0] LOCK_KEY = 16'hA05F,
  parameter logic [31:0] ID_WORD  = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  rdsel_e            rdSel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cardDetect,
  input  logic              writeProt,
  output logic [DATA_W-1:0] rdata,
  output logic              lockOpen,
  output logic              resetReq,
  output logic [MUX_W-1:0]  muxCtrl
);

  localparam board_e            BOARD     = boardOf(ID_WORD);
  localparam int                RST_BIT   = resetTrigBit(BOARD);
  localparam int                WP_BIT    = wpBit(BOARD);
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(clcdKeepMask(BOARD));
  localparam logic [DATA_W-1:0] CLCD_RST  = DATA_W'(clcdInit(BOARD));

  logic [DATA_W-1:0] ledReg, flagReg, nvFlags, resetLevel, clcdReg, mciReg;
  logic [DATA_W-1:0] mciNext;
  logic [LOCK_W-1:0] lockVal;

  assign lockOpen = (lockVal == LOCK_W'(LOCK_KEY));

  always_comb begin
    mciNext         = '0;
    mciNext[0]      = cardDetect;
    mciNext[WP_BIT] = writeProt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledReg     <= '0;
      lockVal    <= '0;
      flagReg    <= '0;
      resetLevel <= '0;
      resetReq   <= 1'b0;
      clcdReg    <= CLCD_RST;
      mciReg     <= '0;
    end else begin
      mciReg   <= mciNext;
      resetReq <= strb.rstWr && wdata[RST_BIT];
      if (strb.ledWr) ledReg <= wdata;
      if (strb.lockWr) begin
        if (wdata == DATA_W'(LOCK_KEY)) lockVal <= LOCK_W'(LOCK_KEY);
        else                            lockVal <= {1'b0, wdata[LOCK_W-2:0]};
      end
      if (strb.flagSet) flagReg <= flagReg | wdata;
      if (strb.flagClr) flagReg <= flagReg & ~wdata;
      if (strb.rstWr)   resetLevel <= wdata;
      if (strb.clcdWr)  clcdReg <= (clcdReg & KEEP_MASK) | (wdata & ~KEEP_MASK);
    end
  end

  // Persistent flags: deliberately outside the reset domain.
  always_ff @(posedge clk) begin
    if (strb.nvSet) nvFlags <= nvFlags | wdata;
    if (strb.nvClr) nvFlags <= nvFlags & ~wdata;
  end

  generate
    if (hasMux(BOARD)) begin : g_mux
      logic [MUX_W-1:0] muxReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            muxReg <= '0;
        else if (strb.clcdWr) muxReg <= wdata[MUX_W-1:0];
      end
      assign muxCtrl = muxReg;
    end else begin : g_nomux
      assign muxCtrl = '0;
    end
  endgenerate

  always_comb begin
    case (rdSel)
      SEL_ID:    rdata = DATA_W'(ID_WORD);
      SEL_LED:   rdata = ledReg;
      SEL_LOCK:  rdata = DATA_W'(lockVal);
      SEL_FLAGS: rdata = flagReg;
      SEL_NV:    rdata = nvFlags;
      SEL_RST:   rdata = resetLevel;
      SEL_MCI:   rdata = mciReg;
      SEL_CLCD:  rdata = clcdReg;
      default:   rdata = '0;
    endcase
  end

  AST_LOCK_FORM: assert property (@(posedge clk) disable iff (!rstN)
    lockVal[LOCK_W-1] |-> (lockVal == LOCK_W'(LOCK_KEY))); // R3
  AST_NV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(nvFlags) |-> $past(strb.nvSet || strb.nvClr)); // R5
  AST_RSTCTL_KEYED: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resetLevel) |-> $past(lockOpen)); // R6
  AST_RSTREQ_KEYED: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(lockOpen)); // R7
  AST_CARD_BIT: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (mciReg[0] == $past(cardDetect))); // R11

  generate
    if ((BOARD == BRD_A) || (BOARD == BRD_B)) begin : g_roChk
      AST_CLCD_RO: assert property (@(posedge clk) disable iff (!rstN)
        clcdReg[13:8] == 6'h1F); // R9
    end
    if (BOARD == BRD_E) begin : g_razChk
      AST_CLCD_RAZ: assert property (@(posedge clk) disable iff (!rstN)
        clcdReg == '0); // R8
    end
  endgenerate

endmodule

// File: rtl/sysstat_bank.sv
module sysstat_bank
  import sysstat_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter int          MUX_W    = 2,
  parameter logic [31:0] ID_WORD  = 32'h0100_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              cardDetect,
  input  logic              writeProt,
  output logic              resetReq,
  output logic [MUX_W-1:0]  muxCtrl
);

  strobe_t strb;
  rdsel_e  rdSel;
  logic    lockOpen;

  sysstat_ctrl #(.ADDR_W(ADDR_W), .ID_WORD(ID_WORD)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .lockOpen (lockOpen),
    .strb     (strb),
    .rdSel    (rdSel)
  );

  sysstat_dp #(
    .DATA_W (DATA_W),
    .MUX_W  (MUX_W),
    .ID_WORD(ID_WORD)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rdSel      (rdSel),
    .wdata      (busWdata),
    .cardDetect (cardDetect),
    .writeProt  (writeProt),
    .rdata      (busRdata),
    .lockOpen   (lockOpen),
    .resetReq   (resetReq),
    .muxCtrl    (muxCtrl)
  );

endmodule

// File: tb/sysstat_bank_test.sv
module sysstat_bank_test;

  localparam int NB = 5;

  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] busAddr;
  logic        busWrite;
  logic [31:0] busWdata;
  logic        cardDetect, writeProt;
  logic [31:0] rdBus  [NB];
  logic        rstReq [NB];
  logic [1:0]  muxOut [NB];

  always #5 clk = ~clk;

  function automatic logic [11:0] codeOf(int g);
    case (g)
      0: return 12'h100;
      1: return 12'h140;
      2: return 12'h178;
      3: return 12'h182;
      default: return 12'h190;
    endcase
  endfunction

  function automatic logic [31:0] idOf(int g);
    return {4'h3, codeOf(g), 16'h7C01};
  endfunction

  generate
    for (genvar g = 0; g < NB; g++) begin : gv
      sysstat_bank #(.ADDR_W(12), .DATA_W(32), .ID_WORD(idOf(g))) uut (
        .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
        .busWdata(busWdata), .busRdata(rdBus[g]), .cardDetect(cardDetect),
        .writeProt(writeProt), .resetReq(rstReq[g]), .muxCtrl(muxOut[g]));
    end
  endgenerate

  int vecs = 0;
  int bad  = 0;

  logic [31:0] mLed[NB], mFlags[NB], mNv[NB], mRst[NB], mClcd[NB];
  logic [15:0] mLock[NB];
  logic [1:0]  mMux[NB];
  logic        expPulse[NB];

  task automatic chk(string tag, int g, logic [31:0] act, logic [31:0] exp, logic [11:0] off);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s inst %0d off %h: got %h expected %h", tag, g, off, act, exp);
    end
  endtask

  function automatic bit hasRst(int g);
    return (g == 0) || (g == 2) || (g == 3);
  endfunction

  function automatic string tagOf(logic [11:0] off);
    case (off)
      12'h00: return "R1";
      12'h08: return "R2";
      12'h20: return "R3";
      12'h30, 12'h34: return "R4";
      12'h38, 12'h3C: return "R5";
      12'h40: return "R6";
      12'h48: return "R11";
      12'h50: return "R8 R9";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [31:0] modelRead(int g, logic [11:0] off);
    logic [31:0] m;
    case (off)
      12'h00: return idOf(g);
      12'h08: return mLed[g];
      12'h20: return {16'h0, mLock[g]};
      12'h30: return mFlags[g];
      12'h38: return mNv[g];
      12'h40: return hasRst(g) ? mRst[g] : 32'h0;
      12'h48: begin
        m = 32'h0;
        m[0] = cardDetect;
        m[(g <= 1) ? 2 : 1] = writeProt;
        return m;
      end
      12'h50: return mClcd[g];
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelWr(logic [11:0] off, logic [31:0] d);
    for (int g = 0; g < NB; g++) begin
      expPulse[g] = 1'b0;
      case (off)
        12'h08: mLed[g] = d;
        12'h20: mLock[g] = (d == 32'h0000A05F) ? 16'hA05F : {1'b0, d[14:0]};
        12'h30: mFlags[g] = mFlags[g] | d;
        12'h34: mFlags[g] = mFlags[g] & ~d;
        12'h38: mNv[g] = mNv[g] | d;
        12'h3C: mNv[g] = mNv[g] & ~d;
        12'h40: if (hasRst(g) && mLock[g] == 16'hA05F) begin
          mRst[g] = d;
          expPulse[g] = (g == 0) ? d[8] : d[2];
        end
        12'h50: begin
          if (g <= 1) mClcd[g] = (mClcd[g] & 32'h3F00) | (d & ~32'h3F00);
          else if (g <= 3) mClcd[g] = (mClcd[g] & ~32'h80) | (d & 32'h80);
          if (g == 0) mMux[g] = d[1:0];
        end
        default: ;
      endcase
    end
  endtask

  task automatic modelReset();
    for (int g = 0; g < NB; g++) begin
      mLed[g] = 0; mLock[g] = 0; mFlags[g] = 0; mRst[g] = 0; mMux[g] = 0;
      mClcd[g] = (g == 4) ? 32'h0 : 32'h1F00;
    end
  endtask

  task automatic busWr(logic [11:0] off, logic [31:0] d);
    @(negedge clk);
    busAddr = off; busWdata = d; busWrite = 1'b1;
    modelWr(off, d);
    @(negedge clk);
    busWrite = 1'b0;
    for (int g = 0; g < NB; g++) begin
      chk("R7", g, {31'h0, rstReq[g]}, {31'h0, expPulse[g]}, off);
      chk("R10", g, {30'h0, muxOut[g]}, {30'h0, mMux[g]}, off);
    end
  endtask

  task automatic readAll();
    for (int w = 0; w < 64; w++) begin
      @(negedge clk);
      busAddr = 12'(w * 4);
      #1;
      for (int g = 0; g < NB; g++) begin
        if (w == 0) chk("R7", g, {31'h0, rstReq[g]}, 32'h0, busAddr);
        chk(tagOf(busAddr), g, rdBus[g], modelRead(g, busAddr), busAddr);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [31:0] pats [8];
    pats = '{32'hFFFFFFFF, 32'h0, 32'hA5A5A5A5, 32'h0000A05F,
             32'h5A5A5A5A, 32'h8000A05F, 32'h00000104, 32'h12345678};
    rstN = 1'b0; busWrite = 1'b0; busAddr = '0; busWdata = '0;
    cardDetect = 1'b0; writeProt = 1'b0;
    for (int g = 0; g < NB; g++) begin mNv[g] = 0; expPulse[g] = 0; end
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    busWr(12'h3C, 32'hFFFFFFFF);  // R5 define persistent flags
    readAll();                    // reset state

    // Sweep every offset with each pattern (R1..R12)
    foreach (pats[i]) begin
      for (int w = 0; w < 64; w++) busWr(12'(w * 4), pats[i]);
      readAll();
    end

    // Key handling and reset trigger (R3, R6, R7)
    busWr(12'h20, 32'h0000A05F);
    busWr(12'h40, 32'h00000104);
    busWr(12'h40, 32'h00000000);
    busWr(12'h20, 32'h8000A05F);
    busWr(12'h40, 32'h000001FF);
    busWr(12'h20, 32'h0000A05F);
    busWr(12'h40, 32'h00000100);
    busWr(12'h40, 32'h00000004);
    busWr(12'h20, 32'h0000FFFF);
    busWr(12'h40, 32'h00000104);
    readAll();

    // Flag set/clear sequencing (R4, R5)
    busWr(12'h30, 32'h0000F0F0);
    busWr(12'h30, 32'h00000F00);
    busWr(12'h34, 32'h000000F0);
    busWr(12'h38, 32'h00FF0000);
    busWr(12'h3C, 32'h000F0000);
    busWr(12'h50, 32'h00000002);  // R10 mux
    readAll();

    // Card pins (R11)
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      cardDetect = c[0];
      writeProt  = c[1];
      readAll();
    end

    // Reset keeps persistent flags (R5) and restores the rest (R2, R8)
    busWr(12'h38, 32'hCAFE0001);
    busWr(12'h08, 32'h13572468);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    readAll();

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule